// File: doc/BRIEF.md
# Local-Bus IDE Port Decoder and Strobe Sequencer

This block sits on a local processor bus and inspects every I/O cycle as its address phase (T1) ends. If the address falls inside one of four fixed IDE port windows, and that connector is switched on, the block claims the cycle so that the ISA path leaves it alone. It then runs the IDE side of the transfer: the IDE enable, one of two chip selects, the two low address lines, a read or write strobe, and finally a one-state ready pulse back to the bus.

An 8-bit control register chooses which connectors respond. It also sets how early the command strobe may start, how long the enable and address are held after the strobe and how long ready is delayed, whether the idle address lines are parked low, and whether the byte-high enable pin carries IDE address bit 2. A register write applies to the next bus cycle that starts. A cycle that is already running keeps its settings. One clock period is one bus T state, and every output is a flop.

Top module: `ide_local_decode`

## Requirements
- R1: Four connectors each own an eight-port data window and a two-port control window: 1F0h–1F7h/3F6h–3F7h, 170h–177h/376h–377h, 5F0h–5F7h/7F6h–7F6h+1, 570h–577h/776h–777h. A data-window hit drives `ide_cs0` and a control-window hit drives `ide_cs1` (both active high, never both). `ide_xa` carries address bits 1:0 of the access.
- R2: Control bits 0..3 switch connectors 1..4 on. An access to a connector that is switched off, or to an address in no window, is never claimed. `ide_en_n` stays high, both chip selects stay low, no strobe falls and `bus_rdy_n` stays high.
- R3: On a hit, `local_claim`, `ide_en_n` (low) and the chip select change at the clock edge that ends T1. `local_claim` drops on the edge after the ready pulse.
- R4: Bit 4 (0 = end of the first T2, 1 = end of the second T2) sets when the command strobe falls for data-window accesses. Control-window accesses always use the end of the first T2. `bus_wr`=1 selects `ide_iow_n`; otherwise `ide_ior_n` is used.
- R5: The command strobe stays low for exactly CMD_T states (CMD_T = 3 by default).
- R6: Bit 5 holds the enable, chip select and address for 1 (bit clear) or 2 (bit set) states after the strobe rises. `bus_rdy_n` pulses low for one state. The pulse begins on the same edge at which `ide_en_n` returns high.
- R7: While no access is running, with bit 6 set, `ide_xa` and `ide_bhe_n` are driven 0. With bit 6 clear they follow `bus_addr[1:0]` and `bus_bhe_n` with one state of delay.
- R8: With bit 7 clear, `ide_bhe_n` follows `bus_bhe_n` during an access. With bit 7 set, it carries address bit 2 of the access, and the command strobe starts one state later.
- R9: A control write made during an access does not change that access. It applies from the next access on. Reset clears the whole control register, including every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| bus_ads | input | 1 | High during T1 of a bus I/O cycle |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | 1 = write cycle, 0 = read |
| bus_bhe_n | input | 1 | Byte-high enable from the bus |
| local_claim | output | 1 | Cycle taken away from the ISA path |
| ide_en_n | output | 1 | IDE buffer enable, active low |
| ide_cs0 | output | 1 | Data-window chip select |
| ide_cs1 | output | 1 | Control-window chip select |
| ide_xa | output | 2 | IDE address bits 1:0 |
| ide_bhe_n | output | 1 | Byte-high enable or IDE address bit 2 |
| ide_ior_n | output | 1 | IDE read strobe, active low |
| ide_iow_n | output | 1 | IDE write strobe, active low |
| bus_rdy_n | output | 1 | Ready to the bus, one-state low pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address and a three-state command pulse. Every stage of the timeline therefore falls at a small, known cycle that can be predicted. The shortest access ends with ready five states after T1, and the longest, with late start, A2 select and long hold, ends eight states after T1. The edges of all four windows are reached directly, along with the neighbouring ports that lie just outside them.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int NUM_CONN = 4;
  localparam logic [11:0] CTRL_OFFSET = 12'h206;

  // bit 7 .. bit 0
  typedef struct packed {
    logic       a2_sel;
    logic       force_dflt;
    logic       hold_long;
    logic       cmd_late;
    logic [3:0] conn_en;
  } ide_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_HOLD,
    ST_DONE
  } seq_st_e;

  // Data window base: odd connectors sit 80h lower, upper pair 400h higher.
  function automatic logic [11:0] data_base(input int idx);
    logic [11:0] b;
    b = 12'h1F0;
    if ((idx % 2) == 1) b = b - 12'h080;
    if (idx >= 2)       b = b + 12'h400;
    return b;
  endfunction

endpackage

// File: rtl/ide_rst_sync.sv
module ide_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ide_cfg_reg.sv
module ide_cfg_reg
  import ide_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ide_cfg_t   cfg
);
  ide_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = ide_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/ide_win_match.sv
module ide_win_match
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_CONN-1:0] conn_en,
  output logic                hit,
  output logic                is_ctrl
);
  logic [NUM_CONN-1:0] data_hit;
  logic [NUM_CONN-1:0] ctrl_hit;

  for (genvar i = 0; i < NUM_CONN; i++) begin : g_win
    localparam logic [ADDR_W-1:0] DBASE = ADDR_W'(data_base(i));
    localparam logic [ADDR_W-1:0] CBASE = ADDR_W'(data_base(i) + CTRL_OFFSET);
    assign data_hit[i] = conn_en[i] && (addr[ADDR_W-1:3] == DBASE[ADDR_W-1:3]);
    assign ctrl_hit[i] = conn_en[i] && (addr[ADDR_W-1:1] == CBASE[ADDR_W-1:1]);
  end

  assign hit     = (|data_hit) || (|ctrl_hit);
  assign is_ctrl = |ctrl_hit;
endmodule

// File: rtl/ide_cycle_seq.sv
module ide_cycle_seq
  import ide_dec_pkg::*;
#(
  parameter int CMD_T = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ads,
  input  logic       hit,
  input  logic       is_ctrl,
  input  logic [2:0] addr_lo,
  input  logic       wr,
  input  logic       bhe_n_in,
  input  logic       cmd_late,
  input  logic       hold_long,
  input  logic       force_dflt,
  input  logic       a2_sel,
  output logic       claim,
  output logic       en_n,
  output logic       cs0,
  output logic       cs1,
  output logic [1:0] xa,
  output logic       bhe_n_out,
  output logic       ior_n,
  output logic       iow_n,
  output logic       rdy_n
);
  localparam int CNT_MAX = (CMD_T > 3) ? CMD_T : 3;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_st_e          st_d, st_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             wr_d, wr_q, hold_d, hold_q, a2s_d, a2s_q, a2b_d, a2b_q;
  logic             claim_d, claim_q, en_d, en_q, cs0_d, cs0_q, cs1_d, cs1_q;
  logic [1:0]       xa_d, xa_q;
  logic             bhe_d, bhe_q, ior_d, ior_q, iow_d, iow_q, rdy_d, rdy_q;
  logic [1:0]       idle_xa;
  logic             idle_bhe, live_bhe;

  always_comb begin
    idle_xa  = force_dflt ? 2'b00 : addr_lo[1:0];
    idle_bhe = force_dflt ? 1'b0  : bhe_n_in;
    live_bhe = a2s_q ? a2b_q : bhe_n_in;

    st_d    = st_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    hold_d  = hold_q;
    a2s_d   = a2s_q;
    a2b_d   = a2b_q;
    claim_d = claim_q;
    en_d    = en_q;
    cs0_d   = cs0_q;
    cs1_d   = cs1_q;
    xa_d    = xa_q;
    bhe_d   = bhe_q;
    ior_d   = ior_q;
    iow_d   = iow_q;
    rdy_d   = rdy_q;

    unique case (st_q)
      ST_IDLE: begin
        claim_d = 1'b0;
        en_d    = 1'b1;
        cs0_d   = 1'b0;
        cs1_d   = 1'b0;
        ior_d   = 1'b1;
        iow_d   = 1'b1;
        rdy_d   = 1'b1;
        xa_d    = idle_xa;
        bhe_d   = idle_bhe;
        if (ads && hit) begin
          st_d    = ST_SETUP;
          cnt_d   = CNT_W'(cmd_late && !is_ctrl) + CNT_W'(a2_sel);
          wr_d    = wr;
          hold_d  = hold_long;
          a2s_d   = a2_sel;
          a2b_d   = addr_lo[2];
          claim_d = 1'b1;
          en_d    = 1'b0;
          cs0_d   = !is_ctrl;
          cs1_d   = is_ctrl;
          xa_d    = addr_lo[1:0];
          bhe_d   = a2_sel ? addr_lo[2] : bhe_n_in;
        end
      end
      ST_SETUP: begin
        bhe_d = live_bhe;
        if (cnt_q == '0) begin
          st_d  = ST_CMD;
          cnt_d = CNT_W'(CMD_T - 1);
          if (wr_q) iow_d = 1'b0;
          else      ior_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CMD: begin
        bhe_d = live_bhe;
        if (cnt_q == '0) begin
          st_d  = ST_HOLD;
          cnt_d = CNT_W'(hold_q);
          ior_d = 1'b1;
          iow_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        bhe_d = live_bhe;
        if (cnt_q == '0) begin
          st_d  = ST_DONE;
          en_d  = 1'b1;
          cs0_d = 1'b0;
          cs1_d = 1'b0;
          xa_d  = idle_xa;
          bhe_d = idle_bhe;
          rdy_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DONE: begin
        st_d    = ST_IDLE;
        rdy_d   = 1'b1;
        claim_d = 1'b0;
        xa_d    = idle_xa;
        bhe_d   = idle_bhe;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      a2s_q   <= 1'b0;
      a2b_q   <= 1'b0;
      claim_q <= 1'b0;
      en_q    <= 1'b1;
      cs0_q   <= 1'b0;
      cs1_q   <= 1'b0;
      xa_q    <= 2'b00;
      bhe_q   <= 1'b0;
      ior_q   <= 1'b1;
      iow_q   <= 1'b1;
      rdy_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      hold_q  <= hold_d;
      a2s_q   <= a2s_d;
      a2b_q   <= a2b_d;
      claim_q <= claim_d;
      en_q    <= en_d;
      cs0_q   <= cs0_d;
      cs1_q   <= cs1_d;
      xa_q    <= xa_d;
      bhe_q   <= bhe_d;
      ior_q   <= ior_d;
      iow_q   <= iow_d;
      rdy_q   <= rdy_d;
    end
  end

  assign claim     = claim_q;
  assign en_n      = en_q;
  assign cs0       = cs0_q;
  assign cs1       = cs1_q;
  assign xa        = xa_q;
  assign bhe_n_out = bhe_q;
  assign ior_n     = ior_q;
  assign iow_n     = iow_q;
  assign rdy_n     = rdy_q;
endmodule

// File: rtl/ide_local_decode.sv
module ide_local_decode
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMD_T  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              bus_ads,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_bhe_n,
  output logic              local_claim,
  output logic              ide_en_n,
  output logic              ide_cs0,
  output logic              ide_cs1,
  output logic [1:0]        ide_xa,
  output logic              ide_bhe_n,
  output logic              ide_ior_n,
  output logic              ide_iow_n,
  output logic              bus_rdy_n
);
  logic     rst_sync_n;
  ide_cfg_t cfg;
  logic     win_hit, win_ctrl;

  ide_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ide_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  ide_win_match #(.ADDR_W(ADDR_W)) u_win (
    .addr    (bus_addr),
    .conn_en (cfg.conn_en),
    .hit     (win_hit),
    .is_ctrl (win_ctrl)
  );

  ide_cycle_seq #(.CMD_T(CMD_T)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ads        (bus_ads),
    .hit        (win_hit),
    .is_ctrl    (win_ctrl),
    .addr_lo    (bus_addr[2:0]),
    .wr         (bus_wr),
    .bhe_n_in   (bus_bhe_n),
    .cmd_late   (cfg.cmd_late),
    .hold_long  (cfg.hold_long),
    .force_dflt (cfg.force_dflt),
    .a2_sel     (cfg.a2_sel),
    .claim      (local_claim),
    .en_n       (ide_en_n),
    .cs0        (ide_cs0),
    .cs1        (ide_cs1),
    .xa         (ide_xa),
    .bhe_n_out  (ide_bhe_n),
    .ior_n      (ide_ior_n),
    .iow_n      (ide_iow_n),
    .rdy_n      (bus_rdy_n)
  );
endmodule

// File: rtl/ide_decode_chk.sv
module ide_decode_chk (
  input logic clk,
  input logic rst_n,
  input logic local_claim,
  input logic ide_en_n,
  input logic ide_cs0,
  input logic ide_cs1,
  input logic ide_ior_n,
  input logic ide_iow_n,
  input logic bus_rdy_n
);
  p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_cs0 && ide_cs1));

  p_unclaimed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !local_claim |-> (ide_en_n && !ide_cs0 && !ide_cs1 && ide_ior_n && ide_iow_n && bus_rdy_n));

  p_claim_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |=> (!local_claim && bus_rdy_n));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_ior_n && !ide_iow_n));

  p_strobe_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_ior_n || !ide_iow_n) |-> (local_claim && !ide_en_n && (ide_cs0 || ide_cs1)));

  p_release_with_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ide_en_n) |-> !bus_rdy_n);

  p_rdy_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |-> (ide_ior_n && ide_iow_n && ide_en_n));
endmodule

bind ide_local_decode ide_decode_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .local_claim (local_claim),
  .ide_en_n    (ide_en_n),
  .ide_cs0     (ide_cs0),
  .ide_cs1     (ide_cs1),
  .ide_ior_n   (ide_ior_n),
  .ide_iow_n   (ide_iow_n),
  .bus_rdy_n   (bus_rdy_n)
);

// File: tb/test_ide_local_decode.sv
module test_ide_local_decode;
  localparam int ADDR_W = 16;
  localparam int CMD_T  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [7:0]        cfg_wdata;
  logic              bus_ads;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic              bus_bhe_n;
  logic              local_claim, ide_en_n, ide_cs0, ide_cs1;
  logic [1:0]        ide_xa;
  logic              ide_bhe_n, ide_ior_n, ide_iow_n, bus_rdy_n;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // per-access observations (cycle index after the edge ending T1)
  int   t_claim, t_fall, t_rise, t_rdy, t_rel, t_unclaim;
  logic s_cs0, s_cs1, s_bhe;
  logic [1:0] s_xa;
  bit   wrong_strobe;

  always #2.5 clk = ~clk;

  ide_local_decode #(.ADDR_W(ADDR_W), .CMD_T(CMD_T)) i_ide_local_decode (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .bus_ads, .bus_addr, .bus_wr, .bus_bhe_n,
    .local_claim, .ide_en_n, .ide_cs0, .ide_cs1, .ide_xa, .ide_bhe_n,
    .ide_ior_n, .ide_iow_n, .bus_rdy_n
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Runs one bus cycle; optional control write at observation index mid_k.
  task automatic run_access(input logic [15:0] a, input logic w, input logic b,
                            input int mid_k, input logic [7:0] mid_v);
    bit claimed, enlow, fell;
    claimed = 0; enlow = 0; fell = 0;
    t_claim = -1; t_fall = -1; t_rise = -1; t_rdy = -1; t_rel = -1; t_unclaim = -1;
    wrong_strobe = 0;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_bhe_n = b; bus_ads = 1'b1;
    @(negedge clk);
    bus_ads = 1'b0;
    for (int k = 0; k < 14; k++) begin
      if (k == 0) begin
        s_cs0 = ide_cs0; s_cs1 = ide_cs1; s_xa = ide_xa; s_bhe = ide_bhe_n;
      end
      if (local_claim && !claimed) begin claimed = 1; t_claim = k; end
      if (!local_claim && claimed && t_unclaim < 0) t_unclaim = k;
      if (!ide_en_n) enlow = 1;
      if (ide_en_n && enlow && t_rel < 0) t_rel = k;
      if (((w ? ide_iow_n : ide_ior_n) == 1'b0) && !fell) begin fell = 1; t_fall = k; end
      if (((w ? ide_iow_n : ide_ior_n) == 1'b1) && fell && t_rise < 0) t_rise = k;
      if ((w ? ide_ior_n : ide_iow_n) == 1'b0) wrong_strobe = 1;
      if (!bus_rdy_n && t_rdy < 0) t_rdy = k;
      if (k == mid_k) begin cfg_we = 1'b1; cfg_wdata = mid_v; end
      else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic expect_timing(input string req, input int s, input int h);
    check({req, " claim at end of T1"}, t_claim, 0);
    check({req, " strobe fall"}, t_fall, s);
    check({req, " strobe rise"}, t_rise, s + CMD_T);
    check({req, " ready"}, t_rdy, s + CMD_T + h);
    check({req, " enable release"}, t_rel, s + CMD_T + h);
    check({req, " claim drop"}, t_unclaim, s + CMD_T + h + 1);
    check({req, " other strobe quiet"}, int'(wrong_strobe), 0);
  endtask

  task automatic expect_ignored(input string req);
    check({req, " no claim"}, t_claim, -1);
    check({req, " no ready"}, t_rdy, -1);
    check({req, " no strobe"}, t_fall, -1);
    check({req, " enable idle"}, int'(ide_en_n), 1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 reset claim", int'(local_claim), 0);
    check("R2 reset enable", int'(ide_en_n), 1);
    check("R2 reset strobes", int'({ide_ior_n, ide_iow_n}), 3);
    check("R2 reset ready", int'(bus_rdy_n), 1);
    check("R1 reset cs", int'({ide_cs0, ide_cs1}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_access(16'h01F0, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R9 reset clears enables");
  endtask

  task automatic t_basic();
    wr_cfg(8'h03);
    run_access(16'h01F2, 1'b0, 1'b1, -1, 8'h00);
    expect_timing("R4 R5 R6 data read", 1, 1);
    check("R1 data cs0", int'(s_cs0), 1);
    check("R1 data cs1", int'(s_cs1), 0);
    check("R1 data xa", int'(s_xa), 2);
    check("R8 bhe pass", int'(s_bhe), 1);
    run_access(16'h0376, 1'b1, 1'b0, -1, 8'h00);
    expect_timing("R3 R4 ctrl write", 1, 1);
    check("R1 ctrl cs1", int'(s_cs1), 1);
    check("R1 ctrl cs0", int'(s_cs0), 0);
    check("R1 ctrl xa", int'(s_xa), 2);
    check("R8 bhe pass low", int'(s_bhe), 0);
    run_access(16'h03F7, 1'b0, 1'b1, -1, 8'h00);
    check("R1 3F7 xa", int'(s_xa), 3);
    check("R1 3F7 cs1", int'(s_cs1), 1);
  endtask

  task automatic t_late_hold();
    wr_cfg(8'h33);
    run_access(16'h0170, 1'b0, 1'b1, -1, 8'h00);
    expect_timing("R4 R6 late data long hold", 2, 2);
    run_access(16'h03F6, 1'b1, 1'b1, -1, 8'h00);
    expect_timing("R4 ctrl ignores late R6", 1, 2);
  endtask

  task automatic t_enables();
    wr_cfg(8'h0C);
    run_access(16'h01F0, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R2 conn1 off");
    run_access(16'h05F0, 1'b0, 1'b1, -1, 8'h00);
    check("R2 conn3 data claimed", t_claim, 0);
    check("R1 conn3 cs0", int'(s_cs0), 1);
    run_access(16'h0776, 1'b1, 1'b1, -1, 8'h00);
    check("R2 conn4 ctrl claimed", t_claim, 0);
    check("R1 conn4 cs1", int'(s_cs1), 1);
    run_access(16'h0577, 1'b0, 1'b1, -1, 8'h00);
    check("R1 conn4 top data port", int'(s_xa), 3);
    wr_cfg(8'h0F);
    run_access(16'h01F8, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R2 past data window");
    run_access(16'h03F5, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R2 below ctrl window");
    run_access(16'h016F, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R2 below conn2 window");
  endtask

  task automatic t_force();
    wr_cfg(8'h41);
    @(negedge clk);
    bus_addr = 16'h01F3; bus_bhe_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 forced xa", int'(ide_xa), 0);
    check("R7 forced bhe", int'(ide_bhe_n), 0);
    wr_cfg(8'h01);
    @(negedge clk);
    check("R7 follow xa", int'(ide_xa), 3);
    check("R7 follow bhe", int'(ide_bhe_n), 1);
  endtask

  task automatic t_a2();
    wr_cfg(8'h81);
    run_access(16'h01F4, 1'b0, 1'b0, -1, 8'h00);
    check("R8 a2 on bhe pin", int'(s_bhe), 1);
    expect_timing("R8 a2 extra setup", 2, 1);
    run_access(16'h01F3, 1'b0, 1'b1, -1, 8'h00);
    check("R8 a2 low on bhe pin", int'(s_bhe), 0);
    wr_cfg(8'h91);
    run_access(16'h01F0, 1'b1, 1'b1, -1, 8'h00);
    expect_timing("R8 R4 late plus a2", 3, 1);
    wr_cfg(8'h01);
    run_access(16'h01F4, 1'b0, 1'b0, -1, 8'h00);
    check("R8 a2 off bhe pass", int'(s_bhe), 0);
  endtask

  task automatic t_midcfg();
    wr_cfg(8'h01);
    run_access(16'h01F1, 1'b0, 1'b1, 1, 8'h21);
    expect_timing("R9 mid write hold unchanged", 1, 1);
    run_access(16'h01F1, 1'b0, 1'b1, -1, 8'h00);
    expect_timing("R9 new hold next access", 1, 2);
    run_access(16'h01F1, 1'b1, 1'b1, 2, 8'h00);
    expect_timing("R9 mid disable completes", 1, 2);
    run_access(16'h01F1, 1'b1, 1'b1, -1, 8'h00);
    expect_ignored("R9 disable applies next");
  endtask

  task automatic t_reset_clear();
    wr_cfg(8'hFF);
    do_reset();
    run_access(16'h01F0, 1'b0, 1'b1, -1, 8'h00);
    expect_ignored("R9 reset clears register");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; bus_ads = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_bhe_n = 1'b1;
    t_reset_state();
    t_basic();
    t_late_hold();
    t_enables();
    t_force();
    t_a2();
    t_midcfg();
    t_reset_clear();
    summary();
    $finish;
  end
endmodule